// File: doc/BRIEF.md
# Index/Data Port Watchdog Timer

This block is a watchdog timer that a host reaches through a two-byte port. Byte offset 0 of the port holds an 8-bit register index. Byte offset 1 is a window onto whichever internal register that index selects. Software first writes the index, then reads or writes the data window. Inside the block are four groups of registers:

- an enable control register;
- an output-routing register;
- a 24-bit reload value spread over three byte registers;
- a service register that carries a reload strobe and a sticky expiry flag.

A tick-enable input stands in for the slow 32768 Hz timebase, and the down-counter advances only on ticked cycles. When the count runs out, the block raises a one-cycle pulse on the reset request output or on the non-maskable interrupt output, as the routing code selects. It also records the event in the expiry flag, then holds until software services it again. The host side is a plain synchronous strobe interface: `wr_en` and `rd_en` with a one-bit offset. Read data is returned combinationally in the same cycle as `rd_en`.

Top module: `idxwdt_top`

## Requirements
- R1: After reset, every implemented register reads 0x00, the index reads 0x00, the timer is disabled and neither output pulses.
- R2: A write at offset 0 sets the index, a read at offset 0 returns it, and offset 1 reads or writes the register the index selects.
- R3: Bit 6 of register 0x37 enables counting. The other bits of that register are stored and read back. Clearing bit 6 halts the count, so no expiry follows.
- R4: The upper nibble of register 0x38 routes the expiry. Code 0xD drives `rst_pulse`, code 0xC drives `nmi_pulse`, and any other code drives neither. The full byte reads back, and the two outputs are never high together.
- R5: Registers 0x39, 0x3A and 0x3B hold bits 7:0, 15:8 and 23:16 of a reload value N. With a tick on every cycle, expiry follows N+1 ticks after the load.
- R6: The counter changes only in cycles where `tick_en` is high. While `tick_en` is low, no expiry happens.
- R7: Writing bit 6 of register 0x3C as 1 loads the counter from the reload value and re-arms it. Bit 6 always reads back as 0.
- R8: A write that takes bit 6 of register 0x37 from 0 to 1 loads the counter from the reload value.
- R9: On expiry, the routed output is high for exactly one cycle, and the counter then stays idle until it is reloaded or re-enabled.
- R10: Bit 7 of register 0x3C is set by expiry and is cleared only by writing it as 0. Writing it as 1 does not set it. Bits 5:0 of that register are stored and read back.
- R11: Indices outside 0x37..0x3C read back 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Timebase enable; the counter advances only when high |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 1 | Port offset: 0 = index, 1 = data window |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, valid while `rd_en` is high, 0 otherwise |
| rst_pulse | output | 1 | One-cycle reset request on expiry |
| nmi_pulse | output | 1 | One-cycle NMI request on expiry |

## Verification
The bench pins the exact expiry cycle after both kinds of load. A design that counts N or N+2 ticks, or that lets a tick in the load cycle also decrement, misses the expected cycle by one.

It runs the timer past expiry with ticks still flowing. A counter that wraps instead of idling produces a second, unexpected pulse. It also steps the timebase by hand, which catches a counter that ignores `tick_en`.

Expiry flag writes are checked in both polarities, and the routing code is checked with an unused value that must still set the flag. A flag that is write-one-to-set, or is tied to the output pulse, reads back wrong. Writes to indices outside the decoded range are followed by read-back of the reload bytes, which exposes partial address decoding.

// File: rtl/idxwdt_pkg.sv
package idxwdt_pkg;

  // register indices seen through the data window
  localparam logic [7:0] IDX_CTRL = 8'h37;
  localparam logic [7:0] IDX_ROUTE = 8'h38;
  localparam logic [7:0] IDX_TMO0 = 8'h39;
  localparam logic [7:0] IDX_SVC = 8'h3C;

  // bit positions
  localparam int CTRL_RUN_BIT = 6;
  localparam int SVC_RELOAD_BIT = 6;
  localparam int SVC_EXPIRED_BIT = 7;

  // routing codes (upper nibble of the routing register)
  localparam logic [3:0] ROUTE_CODE_NMI = 4'hC;
  localparam logic [3:0] ROUTE_CODE_RST = 4'hD;

  typedef enum logic [1:0] {
    DEST_NONE = 2'd0,
    DEST_NMI  = 2'd1,
    DEST_RST  = 2'd2
  } dest_e;

endpackage

// File: rtl/idxwdt_regs.sv
module idxwdt_regs
  import idxwdt_pkg::*;
#(
  parameter int TMR_BYTES = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic                   addr,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata,
  input  logic                   fire_i,
  output logic                   run_o,
  output logic [3:0]             route_code_o,
  output logic [8*TMR_BYTES-1:0] tmo_o,
  output logic                   load_o,
  output logic                   expired_o,
  output logic [7:0]             idx_o
);

  localparam int TMR_W = 8 * TMR_BYTES;

  logic [7:0]       idx_q, idx_d;
  logic [7:0]       ctrl_q, ctrl_d;
  logic [7:0]       route_q, route_d;
  logic [TMR_W-1:0] tmo_q, tmo_d;
  logic [5:0]       svc_lo_q, svc_lo_d;
  logic             expired_q, expired_d;

  logic             wr_idx, wr_dat;
  logic             ctrl_we, route_we, svc_we;
  logic [TMR_BYTES-1:0] tmo_we;
  logic [7:0]       win_data;

  assign wr_idx = wr_en & ~addr;
  assign wr_dat = wr_en & addr;

  // per-byte write enables for the reload value
  for (genvar b = 0; b < TMR_BYTES; b++) begin : g_tmo_we
    localparam logic [7:0] BYTE_IDX = IDX_TMO0 + 8'(b);
    assign tmo_we[b] = wr_dat & (idx_q == BYTE_IDX);
  end

  // next-state logic
  always_comb begin
    ctrl_we  = wr_dat & (idx_q == IDX_CTRL);
    route_we = wr_dat & (idx_q == IDX_ROUTE);
    svc_we   = wr_dat & (idx_q == IDX_SVC);

    idx_d    = wr_idx ? wdata : idx_q;
    ctrl_d   = ctrl_we ? wdata : ctrl_q;
    route_d  = route_we ? wdata : route_q;
    svc_lo_d = svc_we ? wdata[5:0] : svc_lo_q;

    if (fire_i) begin
      expired_d = 1'b1;
    end else if (svc_we && !wdata[SVC_EXPIRED_BIT]) begin
      expired_d = 1'b0;
    end else begin
      expired_d = expired_q;
    end

    for (int b = 0; b < TMR_BYTES; b++) begin
      tmo_d[b*8 +: 8] = tmo_we[b] ? wdata : tmo_q[b*8 +: 8];
    end

    load_o = (ctrl_we & wdata[CTRL_RUN_BIT] & ~ctrl_q[CTRL_RUN_BIT])
           | (svc_we & wdata[SVC_RELOAD_BIT]);
  end

  // data window read mux
  always_comb begin
    win_data = 8'h00;
    if (idx_q == IDX_CTRL) begin
      win_data = ctrl_q;
    end else if (idx_q == IDX_ROUTE) begin
      win_data = route_q;
    end else if (idx_q == IDX_SVC) begin
      win_data = {expired_q, 1'b0, svc_lo_q};
    end
    for (int b = 0; b < TMR_BYTES; b++) begin
      if (idx_q == IDX_TMO0 + 8'(b)) begin
        win_data = tmo_q[b*8 +: 8];
      end
    end
  end

  assign rdata = !rd_en ? 8'h00 : (addr ? win_data : idx_q);

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= '0;
      ctrl_q    <= '0;
      route_q   <= '0;
      tmo_q     <= '0;
      svc_lo_q  <= '0;
      expired_q <= 1'b0;
    end else begin
      idx_q     <= idx_d;
      ctrl_q    <= ctrl_d;
      route_q   <= route_d;
      tmo_q     <= tmo_d;
      svc_lo_q  <= svc_lo_d;
      expired_q <= expired_d;
    end
  end

  assign run_o        = ctrl_q[CTRL_RUN_BIT];
  assign route_code_o = route_q[7:4];
  assign tmo_o        = tmo_q;
  assign expired_o    = expired_q;
  assign idx_o        = idx_q;

endmodule

// File: rtl/idxwdt_counter.sv
module idxwdt_counter #(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             load,
  input  logic [TMR_W-1:0] tmo,
  output logic             fire
);

  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             fire_q, fire_d;

  // load takes priority over a tick in the same cycle
  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    fire_d  = 1'b0;
    if (load) begin
      cnt_d   = tmo;
      armed_d = 1'b1;
    end else if (run && armed_q && tick) begin
      if (cnt_q == '0) begin
        armed_d = 1'b0;
        fire_d  = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      fire_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      fire_q  <= fire_d;
    end
  end

  assign fire = fire_q;

endmodule

// File: rtl/idxwdt_route.sv
module idxwdt_route
  import idxwdt_pkg::*;
(
  input  logic [3:0] code,
  input  logic       fire,
  output logic       rst_pulse,
  output logic       nmi_pulse
);

  dest_e dest;

  always_comb begin
    case (code)
      ROUTE_CODE_NMI: dest = DEST_NMI;
      ROUTE_CODE_RST: dest = DEST_RST;
      default:        dest = DEST_NONE;
    endcase
  end

  assign rst_pulse = fire & (dest == DEST_RST);
  assign nmi_pulse = fire & (dest == DEST_NMI);

endmodule

// File: rtl/idxwdt_top.sv
module idxwdt_top #(
  parameter int TMR_BYTES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       rst_pulse,
  output logic       nmi_pulse
);

  localparam int TMR_W = 8 * TMR_BYTES;

  logic [1:0]       rst_sync_q;
  logic             core_rst_n;
  logic             fire_w;
  logic             run_w;
  logic             load_w;
  logic             expired_w;
  logic [3:0]       code_w;
  logic [7:0]       idx_w;
  logic [TMR_W-1:0] tmo_w;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign core_rst_n = rst_sync_q[1];

  idxwdt_regs #(.TMR_BYTES(TMR_BYTES)) regs_i (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .addr         (addr),
    .wdata        (wdata),
    .rdata        (rdata),
    .fire_i       (fire_w),
    .run_o        (run_w),
    .route_code_o (code_w),
    .tmo_o        (tmo_w),
    .load_o       (load_w),
    .expired_o    (expired_w),
    .idx_o        (idx_w)
  );

  idxwdt_counter #(.TMR_W(TMR_W)) cnt_i (
    .clk   (clk),
    .rst_n (core_rst_n),
    .run   (run_w),
    .tick  (tick_en),
    .load  (load_w),
    .tmo   (tmo_w),
    .fire  (fire_w)
  );

  idxwdt_route route_i (
    .code      (code_w),
    .fire      (fire_w),
    .rst_pulse (rst_pulse),
    .nmi_pulse (nmi_pulse)
  );

endmodule

// File: rtl/idxwdt_chk.sv
module idxwdt_chk
  import idxwdt_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tick_en,
  input logic       rd_en,
  input logic       addr,
  input logic [7:0] rdata,
  input logic       rst_pulse,
  input logic       nmi_pulse,
  input logic       fire,
  input logic       expired,
  input logic       run,
  input logic [7:0] idx
);

  // R9
  one_cycle_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse);

  // R9
  one_cycle_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pulse |=> !nmi_pulse);

  // R4
  exclusive_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_pulse && nmi_pulse));

  // R6
  tick_gated_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> ($past(tick_en) && $past(run)));

  // R10
  expired_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> expired);

  // R11
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr && (idx < IDX_CTRL || idx > IDX_SVC)) |-> (rdata == 8'h00));

endmodule

bind idxwdt_top idxwdt_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .rdata     (rdata),
  .rst_pulse (rst_pulse),
  .nmi_pulse (nmi_pulse),
  .fire      (fire_w),
  .expired   (expired_w),
  .run       (run_w),
  .idx       (idx_w)
);

// File: tb/idxwdt_top_tb_top.sv
module idxwdt_top_tb_top;

  logic       clk;
  logic       rst_n;
  logic       tick_en;
  logic       wr_en;
  logic       rd_en;
  logic       addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       rst_pulse;
  logic       nmi_pulse;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  typedef struct {
    int when;
    bit nmi;
  } exp_t;
  exp_t exp_q[$];

  idxwdt_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .rst_pulse (rst_pulse),
    .nmi_pulse (nmi_pulse)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    addr  = a;
    wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
    bus_wr(1'b0, i);
    bus_wr(1'b1, d);
  endtask

  task automatic reg_rd_chk(input logic [7:0] i, input logic [7:0] expv, input string req);
    bus_wr(1'b0, i);
    @(negedge clk);
    rd_en = 1'b1;
    addr  = 1'b1;
    #2;
    check(rdata == expv, req, int'(rdata), int'(expv));
    rd_en = 1'b0;
  endtask

  task automatic idx_rd_chk(input logic [7:0] expv, input string req);
    @(negedge clk);
    rd_en = 1'b1;
    addr  = 1'b0;
    #2;
    check(rdata == expv, req, int'(rdata), int'(expv));
    rd_en = 1'b0;
  endtask

  task automatic expect_pulse(input int when, input bit nmi);
    exp_t e;
    e.when = when;
    e.nmi  = nmi;
    exp_q.push_back(e);
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic one_tick();
    @(negedge clk);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  // monitor: pops the scoreboard whenever an output pulse appears
  always @(negedge clk) begin
    if (rst_n && (rst_pulse || nmi_pulse)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected pulse", cyc, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.when == cyc, "R5 expiry cycle", cyc, e.when);
        check(nmi_pulse == e.nmi && rst_pulse == !e.nmi, "R4 routed output",
              int'({nmi_pulse, rst_pulse}), e.nmi ? 2 : 1);
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c0;
    rst_n   = 1'b0;
    tick_en = 1'b1;
    wr_en   = 1'b0;
    rd_en   = 1'b0;
    addr    = 1'b0;
    wdata   = 8'h00;
    wait_cycles(3);
    rst_n = 1'b1;
    wait_cycles(4);

    // R1 reset state
    idx_rd_chk(8'h00, "R1 index after reset");
    check(!rst_pulse && !nmi_pulse, "R1 outputs idle", int'({nmi_pulse, rst_pulse}), 0);
    for (int i = 8'h37; i <= 8'h3C; i++) begin
      reg_rd_chk(8'(i), 8'h00, "R1 register after reset");
    end
    wait_cycles(50);

    // R2 index/data access
    bus_wr(1'b0, 8'h3A);
    idx_rd_chk(8'h3A, "R2 index readback");

    // R5 multi-byte reload value, N = 0x000105
    reg_wr(8'h3A, 8'hA5);
    reg_wr(8'h3B, 8'h5A);
    reg_rd_chk(8'h3A, 8'hA5, "R5 middle byte");
    reg_rd_chk(8'h3B, 8'h5A, "R5 upper byte");
    reg_wr(8'h39, 8'h05);
    reg_wr(8'h3A, 8'h01);
    reg_wr(8'h3B, 8'h00);
    reg_rd_chk(8'h39, 8'h05, "R2 data window write/read");

    // R4 routing readback, reset request
    reg_wr(8'h38, 8'hD7);
    reg_rd_chk(8'h38, 8'hD7, "R4 routing readback");

    // R8 enable edge loads, R5 N+1 ticks
    reg_wr(8'h37, 8'h45);
    c0 = cyc;
    expect_pulse(c0 + 262, 1'b0);
    wait_cycles(300);
    check(exp_q.size() == 0, "R8 enable started count", exp_q.size(), 0);
    reg_rd_chk(8'h37, 8'h45, "R3 control readback");
    reg_rd_chk(8'h3C, 8'h80, "R10 expiry flag set");

    // R10 flag writes
    reg_wr(8'h3C, 8'h83);
    reg_rd_chk(8'h3C, 8'h83, "R10 write 1 keeps flag, low bits stored");
    reg_wr(8'h3C, 8'h00);
    reg_rd_chk(8'h3C, 8'h00, "R10 write 0 clears flag");
    reg_wr(8'h3C, 8'h80);
    reg_rd_chk(8'h3C, 8'h00, "R10 write 1 does not set flag");

    // R7 reload via service register, N = 3
    reg_wr(8'h39, 8'h03);
    reg_wr(8'h3A, 8'h00);
    reg_wr(8'h3C, 8'h40);
    c0 = cyc;
    expect_pulse(c0 + 4, 1'b0);
    wait_cycles(30);
    reg_rd_chk(8'h3C, 8'h80, "R7 reload bit reads 0, R9 flag");

    // R3 disabled: reload does not count
    reg_wr(8'h3C, 8'h00);
    reg_wr(8'h37, 8'h05);
    reg_wr(8'h3C, 8'h40);
    wait_cycles(30);
    reg_rd_chk(8'h37, 8'h05, "R3 other bits kept on disable");
    reg_rd_chk(8'h3C, 8'h00, "R3 no expiry while disabled");

    // R8 re-enable reloads
    reg_wr(8'h37, 8'h45);
    c0 = cyc;
    expect_pulse(c0 + 4, 1'b0);
    wait_cycles(10);

    // R3 stop mid-count, N = 20
    reg_wr(8'h39, 8'd20);
    reg_wr(8'h37, 8'h05);
    reg_wr(8'h37, 8'h45);
    reg_wr(8'h37, 8'h05);
    wait_cycles(40);
    reg_rd_chk(8'h3C, 8'h80, "R3 flag from earlier expiry only");
    reg_wr(8'h3C, 8'h00);
    reg_rd_chk(8'h3C, 8'h00, "R3 halted count did not expire");

    // R4 NMI route, N = 2
    reg_wr(8'h38, 8'hC0);
    reg_rd_chk(8'h38, 8'hC0, "R4 NMI code readback");
    reg_wr(8'h39, 8'h02);
    reg_wr(8'h37, 8'h45);
    c0 = cyc;
    expect_pulse(c0 + 3, 1'b1);
    wait_cycles(10);

    // R4 unused code: no output, flag still set
    reg_wr(8'h38, 8'h30);
    reg_wr(8'h3C, 8'h40);
    wait_cycles(10);
    reg_rd_chk(8'h3C, 8'h80, "R4 unused code sets flag without output");

    // R6 manual ticks
    tick_en = 1'b0;
    reg_wr(8'h38, 8'hD0);
    reg_wr(8'h3C, 8'h40);
    wait_cycles(40);
    reg_rd_chk(8'h3C, 8'h00, "R6 no expiry without ticks");
    one_tick();
    wait_cycles(3);
    one_tick();
    wait_cycles(3);
    expect_pulse(cyc + 2, 1'b0);
    one_tick();
    wait_cycles(5);
    check(exp_q.size() == 0, "R6 expiry on third tick", exp_q.size(), 0);

    // R11 unmapped indices
    tick_en = 1'b1;
    reg_wr(8'h50, 8'hFF);
    reg_wr(8'h36, 8'hFF);
    reg_rd_chk(8'h50, 8'h00, "R11 unmapped 0x50 reads 0");
    reg_rd_chk(8'h36, 8'h00, "R11 unmapped 0x36 reads 0");
    reg_rd_chk(8'h39, 8'h02, "R11 low byte untouched");
    reg_rd_chk(8'h3B, 8'h00, "R11 upper byte untouched");
    reg_rd_chk(8'h38, 8'hD0, "R11 routing untouched");

    wait_cycles(5);
    check(exp_q.size() == 0, "R9 all expected pulses seen", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule